// File: doc/BRIEF.md
# UART Receive and Transmit Line Status Unit

This block keeps the error and transmit-empty flags of a UART's line status word. After the receiver has sampled a frame, it hands over the raw line levels of that frame: the data bits, the parity bit and the first stop bit, together with a one-cycle frame-done strobe. The block decides whether the frame carried a break, a framing error or a parity error, and it latches each finding into a sticky flag. Software clears a flag by writing a one to its bit position.

The block also follows the transmit side. A write to the transmit holding register or to the transmit address-in-progress register clears the transmit-empty flag. The flag returns once both registers report that they are unoccupied. A receive-polarity option inverts the meaning of every line level. Force controls let software fake a bad stop bit or a bad parity bit for self-test. A word-length code decides how many data bits take part in the parity and break decisions.

Top module: `uart_line_status`

## Requirements
- R1: After reset the status word reads 0x20: transmit-empty is 1 and every error flag is 0.
- R2: Status bit 2 is the parity error flag, bit 3 the framing error flag, bit 4 the break flag and bit 5 transmit-empty. Every other bit reads 0.
- R3: On a frame-done strobe, the framing flag sets when the logical stop bit is 0 (not at the idle level), or when cfg_force_fe is 1.
- R4: With cfg_par_en=1, the parity flag sets on a frame-done strobe when the XOR of the counted logical data bits and the logical parity bit is 1 (cfg_par_odd=0, even) or 0 (cfg_par_odd=1, odd), or when cfg_force_pe is 1. With cfg_par_en=0 the parity flag never sets, whatever the parity bit or the force control.
- R5: On a frame-done strobe, the break flag sets when the logical stop bit, every counted logical data bit and, if parity is enabled, the logical parity bit are all 0. The force controls do not affect the break flag.
- R6: With cfg_rx_inv=0 the logical level equals the raw level, so the line idles high and a break is the line held low. With cfg_rx_inv=1 every raw level (data, parity and stop) is inverted first, so a break is the line held high.
- R7: fr_len selects the word length: 0, 1, 2 and 3 mean 5, 6, 7 and 8 data bits. Data bits at or above that length have no effect on parity or break.
- R8: Error flags change only in the cycle after a frame-done strobe or a status write. They stay set across later error-free frames.
- R9: A status write clears, in the next cycle, each error flag whose bit position in st_wdata is 1. Zero bits and bit 5 have no effect.
- R10: When a frame sets a flag in the same cycle as a write clears that flag, the flag ends up set.
- R11: A write strobe to either transmit register clears transmit-empty in the next cycle. Without a write strobe, transmit-empty sets when both busy inputs are 0 and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_rx_inv | input | 1 | Receive polarity inversion |
| cfg_force_fe | input | 1 | Treat every stop bit as invalid |
| cfg_force_pe | input | 1 | Treat every parity bit as wrong |
| fr_len | input | 2 | Word length code (5 + code bits) |
| fr_done | input | 1 | One-cycle strobe: frame fields are valid |
| fr_data | input | 8 | Raw sampled data bits, first bit at bit 0 |
| fr_par | input | 1 | Raw sampled parity bit |
| fr_stop | input | 1 | Raw sampled first stop bit |
| tx_hold_wr | input | 1 | Write strobe to the transmit holding register |
| tx_addr_wr | input | 1 | Write strobe to the transmit address-in-progress register |
| tx_hold_busy | input | 1 | Transmit holding register occupied |
| tx_addr_busy | input | 1 | Transmit address-in-progress register occupied |
| st_wr | input | 1 | Status write strobe (write-one-to-clear) |
| st_wdata | input | 8 | Status write data |
| st_rdata | output | 8 | Status word |

## Verification
The assertions take fr_done to be a one-cycle strobe whose frame fields and configuration inputs are settled in that same cycle. They expect the transmit busy inputs to be level signals that may stay high for several cycles, and the set-wins property does not care how wide a status write is. The stimulus changes every input only on the falling clock edge. It raises fr_done for one cycle per frame and holds the configuration steady around each strobe. It overlaps a write-one-to-clear with a frame strobe only in the dedicated priority test.

// File: rtl/uls_pkg.sv
package uls_pkg;
  localparam int STAT_W   = 8;
  localparam int BIT_PE   = 2;
  localparam int BIT_FE   = 3;
  localparam int BIT_BRK  = 4;
  localparam int BIT_THRE = 5;
  localparam int NUM_ERR  = 3;

  typedef enum logic [1:0] {
    ERR_PE  = 2'd0,
    ERR_FE  = 2'd1,
    ERR_BRK = 2'd2
  } err_idx_e;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } err_evt_t;
endpackage

// File: rtl/uls_rst_sync.sv
module uls_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/uls_rx_check.sv
module uls_rx_check
  import uls_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_rx_inv,
  input  logic              cfg_force_fe,
  input  logic              cfg_force_pe,
  input  logic [LEN_W-1:0]  fr_len,
  input  logic [DATA_W-1:0] fr_data,
  input  logic              fr_par,
  input  logic              fr_stop,
  output err_evt_t          evt
);
  localparam int MIN_BITS = DATA_W - (1 << LEN_W) + 1;

  logic [DATA_W-1:0] log_data;
  logic [DATA_W-1:0] in_word;
  logic [DATA_W-1:0] counted;
  logic              log_par;
  logic              log_stop;
  logic              par_sum;
  logic              par_bad;
  logic [31:0]       word_bits;

  assign word_bits = {{(32-LEN_W){1'b0}}, fr_len} + 32'(MIN_BITS);

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_word_mask
      assign in_word[gi] = (word_bits > 32'(gi));
    end
  endgenerate

  always_comb begin
    log_data = fr_data ^ {DATA_W{cfg_rx_inv}};
    log_par  = fr_par ^ cfg_rx_inv;
    log_stop = fr_stop ^ cfg_rx_inv;
    counted  = log_data & in_word;
    par_sum  = (^counted) ^ log_par;
    par_bad  = cfg_par_odd ? ~par_sum : par_sum;

    evt.pe  = cfg_par_en & (par_bad | cfg_force_pe);
    evt.fe  = ~log_stop | cfg_force_fe;
    evt.brk = ~log_stop & ~(|counted) & ~(cfg_par_en & log_par);
  end
endmodule

// File: rtl/uls_sticky_flag.sv
module uls_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_en;
  logic q_d;

  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= 1'b0;
    else if (q_en) q_o <= q_d;
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  // R9
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/uls_tx_empty.sv
module uls_tx_empty (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_wr,
  input  logic addr_wr,
  input  logic hold_busy,
  input  logic addr_busy,
  output logic empty_o
);
  logic any_wr;
  logic idle;
  logic e_en;
  logic e_d;

  always_comb begin
    any_wr = hold_wr | addr_wr;
    idle   = ~hold_busy & ~addr_busy;
    e_en   = any_wr | idle;
    e_d    = ~any_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    empty_o <= 1'b1;
    else if (e_en) empty_o <= e_d;
  end

  // R11
  wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_wr || addr_wr) |=> !empty_o);

  // R11
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_o && (hold_busy || addr_busy)) |=> !empty_o);
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uls_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_rx_inv,
  input  logic              cfg_force_fe,
  input  logic              cfg_force_pe,
  input  logic [LEN_W-1:0]  fr_len,
  input  logic              fr_done,
  input  logic [DATA_W-1:0] fr_data,
  input  logic              fr_par,
  input  logic              fr_stop,
  input  logic              tx_hold_wr,
  input  logic              tx_addr_wr,
  input  logic              tx_hold_busy,
  input  logic              tx_addr_busy,
  input  logic              st_wr,
  input  logic [STAT_W-1:0] st_wdata,
  output logic [STAT_W-1:0] st_rdata
);
  localparam int ERR_POS [NUM_ERR] = '{BIT_PE, BIT_FE, BIT_BRK};

  logic               rst_int_n;
  err_evt_t           evt;
  logic [NUM_ERR-1:0] evt_vec;
  logic [NUM_ERR-1:0] flag_set;
  logic [NUM_ERR-1:0] flag_clr;
  logic [NUM_ERR-1:0] flag_q;
  logic               thre_q;
  logic               unused_wdata;

  uls_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  uls_rx_check #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rx_check (
    .cfg_par_en   (cfg_par_en),
    .cfg_par_odd  (cfg_par_odd),
    .cfg_rx_inv   (cfg_rx_inv),
    .cfg_force_fe (cfg_force_fe),
    .cfg_force_pe (cfg_force_pe),
    .fr_len       (fr_len),
    .fr_data      (fr_data),
    .fr_par       (fr_par),
    .fr_stop      (fr_stop),
    .evt          (evt)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[ERR_PE]  = evt.pe;
    evt_vec[ERR_FE]  = evt.fe;
    evt_vec[ERR_BRK] = evt.brk;
  end

  genvar gf;
  generate
    for (gf = 0; gf < NUM_ERR; gf++) begin : g_flag
      assign flag_set[gf] = fr_done & evt_vec[gf];
      assign flag_clr[gf] = st_wr & st_wdata[ERR_POS[gf]];
      uls_sticky_flag u_flag (
        .clk   (clk),
        .rst_n (rst_int_n),
        .set_i (flag_set[gf]),
        .clr_i (flag_clr[gf]),
        .q_o   (flag_q[gf])
      );
    end
  endgenerate

  uls_tx_empty u_tx_empty (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hold_wr   (tx_hold_wr),
    .addr_wr   (tx_addr_wr),
    .hold_busy (tx_hold_busy),
    .addr_busy (tx_addr_busy),
    .empty_o   (thre_q)
  );

  assign unused_wdata = ^{st_wdata[STAT_W-1:BIT_BRK+1], st_wdata[BIT_PE-1:0]};

  always_comb begin
    st_rdata           = '0;
    st_rdata[BIT_PE]   = flag_q[ERR_PE];
    st_rdata[BIT_FE]   = flag_q[ERR_FE];
    st_rdata[BIT_BRK]  = flag_q[ERR_BRK];
    st_rdata[BIT_THRE] = thre_q;
  end

  // R4
  par_off_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fr_done && !cfg_par_en && !flag_clr[ERR_PE]) |=> $stable(flag_q[ERR_PE]));

  // R5
  brk_fe_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(flag_q[ERR_BRK]) |-> flag_q[ERR_FE]);

  // R8
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!fr_done && !st_wr) |=> $stable(flag_q));
endmodule

// File: tb/uart_line_status_bench.sv
module uart_line_status_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_par_en = 0, cfg_par_odd = 0, cfg_rx_inv = 0;
  logic       cfg_force_fe = 0, cfg_force_pe = 0;
  logic [1:0] fr_len = 2'd3;
  logic       fr_done = 0;
  logic [7:0] fr_data = 8'h00;
  logic       fr_par = 0, fr_stop = 1;
  logic       tx_hold_wr = 0, tx_addr_wr = 0, tx_hold_busy = 0, tx_addr_busy = 0;
  logic       st_wr = 0;
  logic [7:0] st_wdata = 8'h00;
  logic [7:0] st_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_line_status u_uart_line_status (
    .clk(clk), .rst_n(rst_n),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_rx_inv(cfg_rx_inv),
    .cfg_force_fe(cfg_force_fe), .cfg_force_pe(cfg_force_pe),
    .fr_len(fr_len), .fr_done(fr_done), .fr_data(fr_data),
    .fr_par(fr_par), .fr_stop(fr_stop),
    .tx_hold_wr(tx_hold_wr), .tx_addr_wr(tx_addr_wr),
    .tx_hold_busy(tx_hold_busy), .tx_addr_busy(tx_addr_busy),
    .st_wr(st_wr), .st_wdata(st_wdata), .st_rdata(st_rdata)
  );

  // fields: pen odd inv ffe fpe len[1:0] data[7:0] par stop | exp brk fe pe
  function automatic logic [19:0] mk(input logic pen, input logic odd, input logic inv,
      input logic ffe, input logic fpe, input logic [1:0] len, input logic [7:0] d,
      input logic p, input logic s, input logic eb, input logic ef, input logic ep);
    return {pen, odd, inv, ffe, fpe, len, d, p, s, eb, ef, ep};
  endfunction

  localparam int NV = 18;
  localparam logic [19:0] VEC [NV] = '{
    mk(1,0,0,0,0,2'd3,8'h55,0,1, 0,0,0),  // R4 even ok
    mk(1,0,0,0,0,2'd3,8'h55,1,1, 0,0,1),  // R4 even bad
    mk(1,1,0,0,0,2'd3,8'h55,1,1, 0,0,0),  // R4 odd ok
    mk(1,1,0,0,0,2'd3,8'h55,0,1, 0,0,1),  // R4 odd bad
    mk(1,0,0,0,0,2'd3,8'h00,0,0, 1,1,0),  // R5 break
    mk(1,0,0,0,0,2'd3,8'h00,1,0, 0,1,1),  // R5 parity high blocks break
    mk(0,0,0,0,0,2'd3,8'h00,1,0, 1,1,0),  // R5 parity off not counted
    mk(0,0,0,0,0,2'd3,8'h01,0,0, 0,1,0),  // R3 bad stop only
    mk(1,0,1,0,0,2'd3,8'hFF,1,1, 1,1,0),  // R6 inverted break
    mk(1,0,1,0,0,2'd3,8'hAA,1,0, 0,0,0),  // R6 inverted clean
    mk(1,0,0,1,0,2'd3,8'h55,0,1, 0,1,0),  // R3 forced framing
    mk(1,0,0,0,1,2'd3,8'h55,0,1, 0,0,1),  // R4 forced parity
    mk(0,0,0,0,1,2'd3,8'h55,0,1, 0,0,0),  // R4 forced parity disabled
    mk(1,0,0,0,0,2'd0,8'hE0,0,0, 1,1,0),  // R7 5-bit break
    mk(1,0,0,0,0,2'd0,8'hE3,0,1, 0,0,0),  // R7 upper bits ignored
    mk(1,0,0,0,0,2'd1,8'h20,0,1, 0,0,1),  // R7 6-bit counts bit 5
    mk(1,0,0,0,0,2'd3,8'hFF,0,0, 0,1,0),  // R3 stop low, data high
    mk(0,0,1,0,0,2'd3,8'hFE,0,1, 0,1,0)   // R6 inverted stop invalid
  };

  task automatic check(input logic [7:0] exp, input string req);
    n_chk++;
    if (st_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: status actual %02h expected %02h", req, st_rdata, exp);
    end
  endtask

  task automatic status_write(input logic [7:0] d);
    @(negedge clk); st_wr = 1; st_wdata = d;
    @(negedge clk); st_wr = 0; st_wdata = 8'h00;
  endtask

  task automatic load_frame(input logic [19:0] v);
    {cfg_par_en, cfg_par_odd, cfg_rx_inv, cfg_force_fe, cfg_force_pe,
     fr_len, fr_data, fr_par, fr_stop} = v[19:3];
  endtask

  task automatic send_frame(input logic [19:0] v);
    @(negedge clk); load_frame(v); fr_done = 1;
    @(negedge clk); fr_done = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(8'h20, "R1 reset state");  // R1 R2

    for (int i = 0; i < NV; i++) begin
      status_write(8'h1C);
      send_frame(VEC[i]);
      check({2'b00, 1'b1, VEC[i][2:0], 2'b00}, $sformatf("R2 vector %0d", i));
    end

    // R8 sticky across clean frame
    status_write(8'h1C);
    send_frame(VEC[4]);
    send_frame(VEC[0]);
    check(8'h38, "R8 sticky after clean frame");
    // R8 no update without strobe
    @(negedge clk); load_frame(VEC[1]);
    @(negedge clk);
    check(8'h38, "R8 no strobe no change");
    // R9 selective clear, zero write, bit 5 write
    status_write(8'h08);
    check(8'h30, "R9 clear fe only");
    status_write(8'h00);
    check(8'h30, "R9 zero write");
    status_write(8'h20);
    check(8'h30, "R9 bit5 write ignored");
    status_write(8'h10);
    check(8'h20, "R9 clear brk");
    // R10 set beats clear
    @(negedge clk); load_frame(VEC[1]); fr_done = 1; st_wr = 1; st_wdata = 8'h04;
    @(negedge clk); fr_done = 0; st_wr = 0; st_wdata = 8'h00;
    check(8'h24, "R10 set wins");
    status_write(8'h04);
    check(8'h20, "R10 clear afterwards");

    // R11 transmit empty
    @(negedge clk); tx_hold_wr = 1;
    @(negedge clk); tx_hold_wr = 0; tx_hold_busy = 1;
    check(8'h00, "R11 hold write clears");
    @(negedge clk);
    check(8'h00, "R11 busy holds");
    tx_hold_busy = 0; tx_addr_busy = 1;
    @(negedge clk);
    check(8'h00, "R11 addr busy holds");
    tx_addr_busy = 0;
    @(negedge clk);
    check(8'h20, "R11 sets when idle");
    tx_addr_wr = 1;
    @(negedge clk); tx_addr_wr = 0;
    check(8'h00, "R11 addr write clears");
    @(negedge clk);
    check(8'h20, "R11 resets when idle");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule